// File: doc/BRIEF.md
# Audio Sample Rate Mode Detector

This block watches the left/right frame clock of a serial audio stream, whose frequency is the sample rate. It measures the frame clock period in cycles of a free-running reference clock and sorts the rate into one of three operating modes: single speed, double speed or quad speed. The band edges are parameters given as reference-cycle counts. A frame clock that falls in the unsupported band between single and double speed, or that runs faster than quad speed allows, is reported as out of range. A rate change that crosses into another band moves the mode without outside help.

A new result is taken only when two period measurements in a row land in the same band. One odd period therefore cannot move the mode. If no rising frame edge arrives within the count limit, the valid flag drops and the last mode is held. Software can turn auto-detection off with an override bit and supply the mode directly. Auto-detection is in force after reset.

Top module: `srate_mode_detect`

## Requirements
- R1: After a synchronous reset the outputs read mode_o = 2'b00 (single), valid_o = 0 and oor_o = 0.
- R2: With a steady frame clock of period P reference cycles, the outputs settle to valid_o = 1 and oor_o = 0. mode_o is 2'b10 (quad) for QS_MIN <= P <= QS_BOUND, 2'b01 (double) for QS_BOUND < P <= DS_MAX, and 2'b00 (single) for SS_MIN <= P < MAX_CNT.
- R3: With a steady period in the gap (DS_MAX < P < SS_MIN) or below QS_MIN, the outputs settle to oor_o = 1 and valid_o = 0, and mode_o keeps the last accepted mode.
- R4: A new band is accepted only after two consecutive measurements agree. A single period in another band leaves mode_o and valid_o unchanged.
- R5: If no rising frame edge arrives for MAX_CNT reference cycles, valid_o goes to 0, oor_o goes to 0 and mode_o is held. After the frame clock resumes, valid_o returns only after two full agreeing periods.
- R6: When a steady rate moves into another band, mode_o follows with no other input changing.
- R7: While force_en = 1, the cycle after a clock edge shows mode_o = force_mode (value 2'b11 reads as 2'b00), valid_o = 1 and oor_o = 0, whatever the frame clock is doing.
- R8: When force_en returns to 0, the outputs show the detected state, which was kept updated during the override, with no new measurement needed.
- R9: mode_o never reads 2'b11, and valid_o and oor_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Left/right frame clock, asynchronous to clk |
| force_en | input | 1 | 1 disables auto-detection and applies force_mode |
| force_mode | input | 2 | Mode to apply under override (00 single, 01 double, 10 quad, 11 single) |
| mode_o | output | 2 | Selected mode: 00 single, 01 double, 10 quad |
| valid_o | output | 1 | Mode is backed by a current, in-band rate or by the override |
| oor_o | output | 1 | Measured rate lies outside every supported band |

## Verification
The bench sweeps every period from below the quad floor to just under the timeout limit, so each band edge is tested on both sides. A classifier with an off-by-one comparison would report the wrong mode, or a false out-of-range, at exactly one of those periods. A single long period is inserted into a quad-speed stream, followed by a pair of long periods. A design that accepts on one measurement would switch on the single period, and a design with a broken vote would never switch on the pair. The frame clock is stopped and restarted to catch a design that keeps valid high on a dead clock or asserts it after a single period. The override is applied and released while the frame clock is running, to catch a design that loses the detected state during the override.

// File: rtl/srmd_pkg.sv
package srmd_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_NONE   = 2'd3
  } speed_e;
endpackage

// File: rtl/srmd_edge_sync.sv
module srmd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/srmd_period_meter.sv
module srmd_period_meter #(
  parameter int MAX_CNT = 6144,
  localparam int CNT_W = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_CNT - 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      meas     <= '0;
      meas_vld <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      timeout  <= 1'b0;
      if (tick) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) begin
          meas     <= cnt + 1'b1;
          meas_vld <= 1'b1;
        end
      end else if (cnt == LAST) begin
        cnt     <= '0;
        armed   <= 1'b0;
        timeout <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srmd_band_classify.sv
module srmd_band_classify
  import srmd_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int QS_MIN   = 122,
  parameter int QS_BOUND = 246,
  parameter int DS_MAX   = 293,
  parameter int SS_MIN   = 491
) (
  input  logic [CNT_W-1:0] period,
  output speed_e           cls
);
  localparam logic [CNT_W-1:0] Q_LO = CNT_W'(QS_MIN);
  localparam logic [CNT_W-1:0] Q_HI = CNT_W'(QS_BOUND);
  localparam logic [CNT_W-1:0] D_HI = CNT_W'(DS_MAX);
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SS_MIN);

  always_comb begin
    if (period < Q_LO)       cls = SPD_NONE;
    else if (period <= Q_HI) cls = SPD_QUAD;
    else if (period <= D_HI) cls = SPD_DOUBLE;
    else if (period < S_LO)  cls = SPD_NONE;
    else                     cls = SPD_SINGLE;
  end
endmodule

// File: rtl/srmd_mode_decide.sv
module srmd_mode_decide
  import srmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   meas_vld,
  input  speed_e cls,
  input  logic   timeout,
  output speed_e det_mode,
  output logic   det_valid,
  output logic   det_oor
);
  speed_e prev_cls;
  logic   prev_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cls  <= SPD_NONE;
      prev_ok   <= 1'b0;
      det_mode  <= SPD_SINGLE;
      det_valid <= 1'b0;
      det_oor   <= 1'b0;
    end else if (timeout) begin
      prev_ok   <= 1'b0;
      det_valid <= 1'b0;
      det_oor   <= 1'b0;
    end else if (meas_vld) begin
      prev_cls <= cls;
      prev_ok  <= 1'b1;
      if (prev_ok && prev_cls == cls) begin
        if (cls == SPD_NONE) begin
          det_valid <= 1'b0;
          det_oor   <= 1'b1;
        end else begin
          det_mode  <= cls;
          det_valid <= 1'b1;
          det_oor   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/srate_mode_detect.sv
module srate_mode_detect
  import srmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QS_MIN      = 122,
  parameter int QS_BOUND    = 246,
  parameter int DS_MAX      = 293,
  parameter int SS_MIN      = 491,
  parameter int MAX_CNT     = 6144
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_clk,
  input  logic       force_en,
  input  logic [1:0] force_mode,
  output logic [1:0] mode_o,
  output logic       valid_o,
  output logic       oor_o
);
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  logic             rise;
  logic             mvld;
  logic [CNT_W-1:0] period;
  logic             tmo;
  speed_e           cls;
  speed_e           det_mode;
  logic             det_valid;
  logic             det_oor;

  srmd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(frame_clk), .rise(rise)
  );

  srmd_period_meter #(.MAX_CNT(MAX_CNT)) u_meter (
    .clk(clk), .rst(rst), .tick(rise),
    .meas_vld(mvld), .meas(period), .timeout(tmo)
  );

  srmd_band_classify #(
    .CNT_W(CNT_W), .QS_MIN(QS_MIN), .QS_BOUND(QS_BOUND),
    .DS_MAX(DS_MAX), .SS_MIN(SS_MIN)
  ) u_cls (
    .period(period), .cls(cls)
  );

  srmd_mode_decide u_dec (
    .clk(clk), .rst(rst), .meas_vld(mvld), .cls(cls), .timeout(tmo),
    .det_mode(det_mode), .det_valid(det_valid), .det_oor(det_oor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= SPD_SINGLE;
      valid_o <= 1'b0;
      oor_o   <= 1'b0;
    end else if (force_en) begin
      mode_o  <= (force_mode == 2'b11) ? SPD_SINGLE : force_mode;
      valid_o <= 1'b1;
      oor_o   <= 1'b0;
    end else begin
      mode_o  <= det_mode;
      valid_o <= det_valid;
      oor_o   <= det_oor;
    end
  end
endmodule

// File: rtl/srmd_checker.sv
module srmd_checker (
  input logic       clk,
  input logic       rst,
  input logic       force_en,
  input logic [1:0] force_mode,
  input logic [1:0] mode_o,
  input logic       valid_o,
  input logic       oor_o,
  input logic       tmo
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b11); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && oor_o)); // R9

  AST_FORCE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    force_en |=> (valid_o && !oor_o)); // R7

  AST_FORCE_MODE: assert property (@(posedge clk) disable iff (rst)
    (force_en && force_mode != 2'b11) |=> (mode_o == $past(force_mode))); // R7

  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (rst)
    (tmo && !force_en) ##1 !force_en |=> (!valid_o && !oor_o)); // R5
endmodule

bind srate_mode_detect srmd_checker u_chk (
  .clk(clk), .rst(rst), .force_en(force_en), .force_mode(force_mode),
  .mode_o(mode_o), .valid_o(valid_o), .oor_o(oor_o), .tmo(tmo)
);

// File: tb/srate_mode_detect_test.sv
module srate_mode_detect_test;
  localparam int QS_MIN   = 8;
  localparam int QS_BOUND = 16;
  localparam int DS_MAX   = 20;
  localparam int SS_MIN   = 26;
  localparam int MAX_CNT  = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_clk = 1'b0;
  logic       force_en = 1'b0;
  logic [1:0] force_mode = 2'b00;
  logic [1:0] mode_o;
  logic       valid_o;
  logic       oor_o;

  int total = 0;
  int bad = 0;
  int last_good = 0;

  always #4 clk = ~clk;

  srate_mode_detect #(
    .QS_MIN(QS_MIN), .QS_BOUND(QS_BOUND), .DS_MAX(DS_MAX),
    .SS_MIN(SS_MIN), .MAX_CNT(MAX_CNT)
  ) uut (
    .clk(clk), .rst(rst), .frame_clk(frame_clk), .force_en(force_en),
    .force_mode(force_mode), .mode_o(mode_o), .valid_o(valid_o), .oor_o(oor_o)
  );

  // expected band code from the requirement text; 3 means out of range
  function automatic int band_of(input int p);
    if (p < QS_MIN) return 3;
    if (p <= QS_BOUND) return 2;
    if (p <= DS_MAX) return 1;
    if (p < SS_MIN) return 3;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input int t, input int n);
    for (int k = 0; k < n; k++) begin
      frame_clk = 1'b1;
      repeat (t / 2) @(negedge clk);
      frame_clk = 1'b0;
      repeat (t - t / 2) @(negedge clk);
    end
  endtask

  task automatic expect_state(input string req, input int m, input int v, input int o);
    chk(req, "mode", int'(mode_o), m);
    chk(req, "valid", int'(valid_o), v);
    chk(req, "oor", int'(oor_o), o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R1", 0, 0, 0);

    // R2 R3 R6: sweep every period, ascending across all bands
    for (int t = 4; t < MAX_CNT; t++) begin
      int b;
      drive(t, 6);
      b = band_of(t);
      if (b == 3) expect_state("R3", last_good, 0, 1);
      else begin
        last_good = b;
        expect_state("R2", b, 1, 0);
      end
    end

    // R6: direct jump from single to quad and to double
    drive(12, 6);
    expect_state("R6", 2, 1, 0);
    drive(40, 6);
    expect_state("R6", 0, 1, 0);
    drive(18, 6);
    expect_state("R6", 1, 1, 0);

    // R4: one odd period is rejected, two agreeing ones are accepted
    drive(12, 6);
    expect_state("R4", 2, 1, 0);
    drive(30, 1);
    expect_state("R4", 2, 1, 0);
    drive(12, 1);
    expect_state("R4", 2, 1, 0);
    drive(12, 3);
    expect_state("R4", 2, 1, 0);
    drive(30, 2);
    drive(12, 1);
    expect_state("R4", 0, 1, 0);
    drive(12, 4);
    expect_state("R4", 2, 1, 0);

    // R5: stopped frame clock
    frame_clk = 1'b0;
    repeat (MAX_CNT + 12) @(negedge clk);
    expect_state("R5", 2, 0, 0);
    drive(18, 2);
    expect_state("R5", 2, 0, 0);
    drive(18, 2);
    expect_state("R5", 1, 1, 0);

    // R7 R8: override while the frame clock keeps running
    drive(18, 4);
    fork
      drive(18, 10);
      begin
        repeat (30) @(negedge clk);
        force_en = 1'b1;
        force_mode = 2'b10;
        repeat (2) @(negedge clk);
        expect_state("R7", 2, 1, 0);
        force_en = 1'b0;
        repeat (2) @(negedge clk);
        expect_state("R8", 1, 1, 0);
      end
    join

    // R7: override over a stopped clock and over an out-of-range rate
    frame_clk = 1'b0;
    repeat (MAX_CNT + 12) @(negedge clk);
    force_en = 1'b1;
    force_mode = 2'b11;
    repeat (2) @(negedge clk);
    expect_state("R7", 0, 1, 0);
    force_mode = 2'b01;
    repeat (2) @(negedge clk);
    expect_state("R7", 1, 1, 0);
    drive(22, 6);
    expect_state("R7", 1, 1, 0);
    force_en = 1'b0;
    repeat (2) @(negedge clk);
    expect_state("R8", 1, 0, 1);

    // R1: reset again from a non-default state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R1", 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule